// File: doc/BRIEF.md
# Keyed Window Watchdog

This block is a watchdog counter driven by a reference clock. A 3-bit select field in a small control register sets the timeout period, or turns the counter off when the field is zero. While the counter is on, software must write the byte 0x55 and then the byte 0xAA to a write-only service port before the period runs out. A completed pair clears the count and starts a new period. If the period runs out, or if software writes a byte that is not one of the two keys, the block raises a one-cycle reset request for the system reset logic.

In window mode, service writes are accepted only in the last quarter of the period. A write made earlier is treated as a fault. In this mode, an 0xAA that does not follow an 0x55 is also a fault. Two more control bits and two mode inputs decide whether counting goes on during stop and wait low-power states. The parameter `SCALE` shortens every period by the same power of two, so that a small configuration can be exercised in full.

Top module: `keyed_window_watchdog`

## Requirements
- R1: When select field ctl_wdata[2:0] is 000, the watchdog is off. The count is held at zero and rst_req never asserts.
- R2: While the watchdog is off, service writes of any byte, including bytes that would otherwise be faults, change nothing.
- R3: svc_rdata is 0x00 at all times.
- R4: A period restarts only when 0xAA is written after an earlier 0x55 in the same period. The next timeout then comes P cycles after the 0xAA write. An 0xAA with no 0x55 before it does not restart the period.
- R5: A service write of any byte other than 0x55 or 0xAA, with the watchdog on, sets rst_req in the cycle after the write edge.
- R6: Select values 1 to 7 give periods P of 2^(14,16,18,20,22,23,24 minus SCALE) cycles. When nothing services the watchdog, rst_req asserts P cycles after the control write or after the last restart.
- R7: With window mode off (ctl_wdata[3]=0), repeated 0x55 writes and repeated 0xAA writes cause no reset.
- R8: With window mode on, a service write made while the count is below 3P/4 raises rst_req at once. A write made while the count is at or above 3P/4 is accepted.
- R9: With window mode on, an 0xAA not preceded by 0x55 raises rst_req at once, even inside the window.
- R10: In stop mode, the counter halts unless the stop-run bit ctl_wdata[4] is set.
- R11: In wait mode, the counter halts when the wait-halt bit ctl_wdata[5] is set, and runs when that bit is clear.
- R12: rst_req lasts one cycle. In the same cycle it clears both the count and any pending 0x55, so a later 0xAA does not restart the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control fields: [2:0] period select, [3] window mode, [4] stop-run, [5] wait-halt |
| svc_wr | input | 1 | Service port write strobe |
| svc_wdata | input | 8 | Service byte |
| svc_rdata | output | 8 | Service port read data (always zero) |
| stop_mode | input | 1 | Chip is in stop mode |
| wait_mode | input | 1 | Chip is in wait mode |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
All seven select values run unserviced, so each measured timeout matches exactly one period and a wrong decode is caught. Every non-key byte is written in turn to separate the two keys from all other bytes. Ordered, repeated and unpaired key patterns show which sequences restart the period and which are ignored. Window writes are placed one cycle either side of the three-quarter boundary, and the low-power inputs are held with each control bit set and clear, to tell frozen counting from running counting.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef struct packed {
        logic       wait_halt;
        logic       stop_run;
        logic       window;
        logic [2:0] sel;
    } wdk_ctl_t;

    localparam int unsigned CTL_W = $bits(wdk_ctl_t);

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;

    // log2 of the full-size period for each select value
    function automatic logic [4:0] sel_exp(input logic [2:0] sel);
        case (sel)
            3'd1:    sel_exp = 5'd14;
            3'd2:    sel_exp = 5'd16;
            3'd3:    sel_exp = 5'd18;
            3'd4:    sel_exp = 5'd20;
            3'd5:    sel_exp = 5'd22;
            3'd6:    sel_exp = 5'd23;
            default: sel_exp = 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/wdk_ctrl.sv
module wdk_ctrl
    import wdk_pkg::*;
#(
    parameter int unsigned CNT_W = 24,
    parameter int unsigned SCALE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             stop_mode,
    input  logic             wait_mode,
    output logic             enabled,
    output logic             window_en,
    output logic             run,
    output logic [CNT_W-1:0] last_cnt,
    output logic [CNT_W-1:0] win_start
);

    typedef struct packed {
        wdk_ctl_t ctl;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;
    logic [4:0]   shamt;
    logic [CNT_W:0] per_full;

    always_comb begin
        s_d = s_q;
        if (ctl_wr) begin
            s_d.ctl = wdk_ctl_t'(ctl_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        shamt     = sel_exp(s_q.ctl.sel) - 5'(SCALE);
        per_full  = {{CNT_W{1'b0}}, 1'b1} << shamt;
        last_cnt  = per_full[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
        win_start = per_full[CNT_W-1:0] - per_full[CNT_W:2];
        enabled   = (s_q.ctl.sel != 3'd0);
        window_en = s_q.ctl.window;
        run       = enabled
                  && !(stop_mode && !s_q.ctl.stop_run)
                  && !(wait_mode && s_q.ctl.wait_halt);
    end

    AST_RUN_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> enabled) else $error("run while off"); // R1

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enabled,
    input  logic             run,
    input  logic [CNT_W-1:0] last_cnt,
    input  logic [CNT_W-1:0] win_start,
    input  logic             kick,
    input  logic             bad,
    output logic             win_open,
    output logic             timeout,
    output logic             rst_req
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rst;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        timeout  = run && (s_q.cnt >= last_cnt);
        win_open = (s_q.cnt >= win_start);
        s_d.rst  = bad || timeout;
        if (!enabled || bad || timeout || kick) begin
            s_d.cnt = '0;
        end else if (run) begin
            s_d.cnt = s_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_req = s_q.rst;

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rst |-> (s_q.cnt == '0)) else $error("count kept on reset"); // R12
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> (s_q.cnt == '0)) else $error("count while off"); // R1
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !run && !kick && !bad) |=> $stable(s_q.cnt)) else $error("count moved while halted"); // R10
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (s_q.cnt == '0)) else $error("restart lost"); // R4

endmodule

// File: rtl/wdk_key.sv
module wdk_key
    import wdk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       svc_wr,
    input  logic [7:0] svc_wdata,
    input  logic       enabled,
    input  logic       window_en,
    input  logic       win_open,
    input  logic       timeout,
    output logic       kick,
    output logic       bad
);

    typedef struct packed {
        logic armed;
    } key_state_t;

    key_state_t s_d, s_q;
    logic is_arm, is_fire;

    always_comb begin
        s_d     = s_q;
        kick    = 1'b0;
        bad     = 1'b0;
        is_arm  = (svc_wdata == KEY_ARM);
        is_fire = (svc_wdata == KEY_FIRE);
        if (!enabled) begin
            s_d.armed = 1'b0;
        end else if (svc_wr) begin
            if (!is_arm && !is_fire) begin
                bad = 1'b1;
            end else if (window_en && !win_open) begin
                bad = 1'b1;
            end else if (is_fire && !s_q.armed && window_en) begin
                bad = 1'b1;
            end else if (is_arm) begin
                s_d.armed = 1'b1;
            end else if (s_q.armed) begin
                kick      = 1'b1;
                s_d.armed = 1'b0;
            end
        end
        if (bad || timeout) begin
            s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bad || timeout) |=> !s_q.armed) else $error("pending key survived reset"); // R12
    AST_KICK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> s_q.armed) else $error("restart without arm key"); // R4

endmodule

// File: rtl/keyed_window_watchdog.sv
module keyed_window_watchdog
    import wdk_pkg::*;
#(
    parameter int unsigned CNT_W = 24,
    parameter int unsigned SCALE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             svc_wr,
    input  logic [7:0]       svc_wdata,
    output logic [7:0]       svc_rdata,
    input  logic             stop_mode,
    input  logic             wait_mode,
    output logic             rst_req
);

    logic             enabled;
    logic             window_en;
    logic             run;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] win_start;
    logic             win_open;
    logic             timeout;
    logic             kick;
    logic             bad;

    wdk_ctrl #(.CNT_W(CNT_W), .SCALE(SCALE)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .stop_mode (stop_mode),
        .wait_mode (wait_mode),
        .enabled   (enabled),
        .window_en (window_en),
        .run       (run),
        .last_cnt  (last_cnt),
        .win_start (win_start)
    );

    wdk_key i_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .svc_wr    (svc_wr),
        .svc_wdata (svc_wdata),
        .enabled   (enabled),
        .window_en (window_en),
        .win_open  (win_open),
        .timeout   (timeout),
        .kick      (kick),
        .bad       (bad)
    );

    wdk_counter #(.CNT_W(CNT_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enabled   (enabled),
        .run       (run),
        .last_cnt  (last_cnt),
        .win_start (win_start),
        .kick      (kick),
        .bad       (bad),
        .win_open  (win_open),
        .timeout   (timeout),
        .rst_req   (rst_req)
    );

    assign svc_rdata = 8'h00;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enabled) |-> !rst_req) else $error("reset while off"); // R1
    AST_BAD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && enabled && svc_wdata != KEY_ARM && svc_wdata != KEY_FIRE) |=> rst_req)
        else $error("foreign byte not punished"); // R5
    AST_EARLY_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && enabled && window_en && !win_open) |=> rst_req)
        else $error("early window write not punished"); // R8

endmodule

// File: tb/test_keyed_window_watchdog.sv
module test_keyed_window_watchdog;

    localparam int SCALE = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_wr;
    logic [5:0] ctl_wdata;
    logic       svc_wr;
    logic [7:0] svc_wdata;
    logic [7:0] svc_rdata;
    logic       stop_mode;
    logic       wait_mode;
    logic       rst_req;

    int checks = 0;
    int errors = 0;
    int t = 0;
    int rst_hits = 0;
    int rst_t = -1;
    int ro_bad = 0;

    always #5 clk = ~clk;

    keyed_window_watchdog #(.CNT_W(24), .SCALE(SCALE)) i_keyed_window_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .svc_wr    (svc_wr),
        .svc_wdata (svc_wdata),
        .svc_rdata (svc_rdata),
        .stop_mode (stop_mode),
        .wait_mode (wait_mode),
        .rst_req   (rst_req)
    );

    function automatic int per(input int s);
        int e;
        case (s)
            1: e = 14; 2: e = 16; 3: e = 18; 4: e = 20;
            5: e = 22; 6: e = 23; default: e = 24;
        endcase
        return 1 << (e - SCALE);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        t++;
        @(negedge clk);
        if (rst_req) begin
            rst_hits++;
            rst_t = t;
        end
        if (svc_rdata != 8'h00) ro_bad++;
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    task automatic ctl(input int v);
        ctl_wr = 1'b1; ctl_wdata = 6'(v);
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic svc(input int v);
        svc_wr = 1'b1; svc_wdata = 8'(v);
        step();
        svc_wr = 1'b0;
    endtask

    task automatic wait_rst(input int limit);
        int h = rst_hits;
        int n = 0;
        while (rst_hits == h && n < limit) begin
            step();
            n++;
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", t, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        int h, t0, ta, tr, tq, tw;
        rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; svc_wr = 1'b0;
        svc_wdata = '0; stop_mode = 1'b0; wait_mode = 1'b0;
        repeat (3) @(negedge clk);
        check(rst_req == 1'b0, "R12", "rst_req in reset", int'(rst_req), 0);
        check(svc_rdata == 8'h00, "R3", "read data in reset", int'(svc_rdata), 0);
        rst_n = 1'b1;

        // R1 / R2: off, then foreign and key bytes
        ctl(0);
        h = rst_hits;
        run(50);
        check(rst_hits == h, "R1", "resets while off", rst_hits - h, 0);
        svc(8'h13); svc(8'h55); svc(8'hAA); svc(8'h00);
        run(20);
        check(rst_hits == h, "R2", "resets from writes while off", rst_hits - h, 0);

        // R6: period sweep
        for (int s = 1; s <= 7; s++) begin
            ctl(s); t0 = t;
            wait_rst(per(s) + 5);
            check(rst_t - t0 == per(s), "R6", $sformatf("period sel %0d", s), rst_t - t0, per(s));
            ctl(0);
        end

        // R4: ordered pair restarts
        ctl(1); t0 = t;
        run(3); svc(8'h55); run(2); svc(8'hAA); ta = t;
        wait_rst(40);
        check(rst_t - ta == 16, "R4", "timeout after pair", rst_t - ta, 16);
        ctl(0);

        // R4: lone 0xAA does not restart
        ctl(1); t0 = t;
        run(3); svc(8'hAA);
        wait_rst(40);
        check(rst_t - t0 == 16, "R4", "lone AA restart", rst_t - t0, 16);
        ctl(0);

        // R12: pending 0x55 dropped by timeout
        ctl(1); t0 = t;
        run(2); svc(8'h55);
        wait_rst(40); tr = rst_t;
        check(tr - t0 == 16, "R12", "timeout with pending arm", tr - t0, 16);
        run(1); svc(8'hAA);
        wait_rst(40);
        check(rst_t - tr == 16, "R12", "AA after reset restarted", rst_t - tr, 16);
        ctl(0);

        // R5: every foreign byte
        ctl(3);
        for (int v = 0; v < 256; v++) begin
            if (v == 8'h55 || v == 8'hAA) continue;
            h = rst_hits;
            svc(v); tw = t;
            check(rst_hits == h + 1 && rst_t == tw, "R5",
                  $sformatf("byte %0d reset delay", v), rst_t - tw, 0);
            run(1);
        end
        wait_rst(300);
        check(rst_t - tw == per(3), "R12", "count cleared by pulse", rst_t - tw, per(3));
        ctl(0);

        // R7: repeats without window
        ctl(1);
        run(2); svc(8'h55); svc(8'h55); svc(8'h55); h = rst_hits;
        svc(8'hAA); ta = t; svc(8'hAA); svc(8'hAA);
        check(rst_hits == h, "R7", "reset from repeats", rst_hits - h, 0);
        wait_rst(40);
        check(rst_t - ta == 16, "R7", "restart point", rst_t - ta, 16);
        ctl(0);

        // R8: window boundary, sel 2 (P=64, opens at count 48)
        ctl(8 + 2); t0 = t;
        run(47); h = rst_hits;
        svc(8'h55);
        check(rst_hits == h + 1 && rst_t == t, "R8", "write at count 47", rst_t - t, 0);
        tr = t;
        run(48); h = rst_hits;
        svc(8'h55); run(1); svc(8'h55); svc(8'hAA); ta = t;
        check(rst_hits == h, "R8", "resets from window writes", rst_hits - h, 0);
        wait_rst(80); tq = rst_t;
        check(tq - ta == 64, "R8", "restart in window", tq - ta, 64);

        // R9: unarmed 0xAA inside window
        run(49); h = rst_hits;
        svc(8'hAA);
        check(rst_hits == h + 1 && rst_t == t, "R9", "lone AA in window", rst_hits - h, 1);
        ctl(0);

        // R10: stop mode
        stop_mode = 1'b1;
        ctl(1); h = rst_hits;
        run(100);
        check(rst_hits == h, "R10", "halted in stop", rst_hits - h, 0);
        stop_mode = 1'b0; tw = t;
        wait_rst(40);
        check(rst_t - tw == 16, "R10", "resume after stop", rst_t - tw, 16);
        ctl(0);
        stop_mode = 1'b1;
        ctl(16 + 1); t0 = t;
        wait_rst(40);
        check(rst_t - t0 == 16, "R10", "run through stop", rst_t - t0, 16);
        stop_mode = 1'b0;
        ctl(0);

        // R11: wait mode
        wait_mode = 1'b1;
        ctl(32 + 1); h = rst_hits;
        run(100);
        check(rst_hits == h, "R11", "halted in wait", rst_hits - h, 0);
        wait_mode = 1'b0; tw = t;
        wait_rst(40);
        check(rst_t - tw == 16, "R11", "resume after wait", rst_t - tw, 16);
        ctl(0);
        wait_mode = 1'b1;
        ctl(1); t0 = t;
        wait_rst(40);
        check(rst_t - t0 == 16, "R11", "run through wait", rst_t - t0, 16);
        wait_mode = 1'b0;
        ctl(0);

        check(ro_bad == 0, "R3", "nonzero read samples", ro_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule